// File: doc/BRIEF.md
# Display PLL Divider Parameter Calculator

This block turns a requested pixel clock, given in kHz, into the two words that program a display PHY's transmit PLL. The first is an 11-bit control word that packs a post-divider code, an output-divider code and a display divider. The second is a 32-bit fixed-point loop-setting word. The intermediate VCO rate comes from one of two formulas. In LVDS mode it depends on the link count. In DSI mode it depends on the bits per pixel and the lane count.

A request is taken through a valid/ready handshake. The requester holds `in_valid` and the operand pins steady until it sees `in_ready` high at a clock edge; that edge captures the operands. While a calculation is running, `in_ready` is low and nothing on the request pins has any effect. This is the only back-pressure. The results have no back-pressure. `done` pulses once, and `pll_word` and `set_word` then hold their values until the next `done`. All six divisions go through one shared restoring divider that resolves one quotient bit per clock. The power-of-two gain comes from a combinational leading-one search.

Top module: `dpll_param_calc`

## Requirements
- R1: `in_ready` is high exactly when no calculation is running. A request is accepted at a rising edge where `in_valid` and `in_ready` are both high. `in_valid` seen while `in_ready` is low has no effect on any output.
- R2: The scaled VCO rate V is floor(clk_khz*70/lane_cnt) when `mode_dsi`=0 (LVDS, where lane_cnt is the link count). It is floor(clk_khz*bpp*10/lane_cnt) when `mode_dsi`=1.
- R3: The gain is 2^d, where d = floor(log2(max(1, floor(25000000/V)))). A leading-one search of an input of 0 or 1 yields 0.
- R4: Let C = floor(V*2^d/10). `pll_word[7:0]` equals the low 8 bits of floor(C/clk_khz).
- R5: `pll_word[9:8]` equals min(3,d). `pll_word[10]` equals the low bit of d-min(3,d). As a result, bit 10 is 0 whenever bits 9:8 are below 3.
- R6: Let G = floor(C/266000) rounded up to the next multiple of 8 (a multiple of 8 is kept as it is). `set_word` equals the low 32 bits of floor((1200000*G*2^26)/C).
- R7: `done` is a single-cycle pulse. It comes exactly 6*(NUM_W+2) clock cycles after the accepting edge, which is 396 cycles with the default NUM_W=64. `in_ready` is low from the accepting edge until the edge that raises `done`.
- R8: A request is rejected if clk_khz=0, if lane_cnt=0, or if `mode_dsi`=1 with bpp=0. A rejected request raises `error` for one cycle after the accepting edge, raises no `done`, leaves both output words unchanged and keeps `in_ready` high.
- R9: `pll_word` and `set_word` change only on the edge that raises `done`.
- R10: During and right after reset, `in_ready`=1, `done`=0, `error`=0 and both output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request can be taken |
| mode_dsi | input | 1 | 1 selects the DSI VCO formula, 0 selects LVDS |
| clk_khz | input | CLK_W (20) | Target pixel clock in kHz |
| bpp | input | BPP_W (6) | Bits per pixel (DSI mode only) |
| lane_cnt | input | CNT_W (3) | Lane count (DSI) or link count (LVDS) |
| done | output | 1 | One-cycle pulse, output words are new |
| error | output | 1 | One-cycle pulse, request rejected |
| pll_word | output | 11 | Packed divider control word |
| set_word | output | 32 | Loop-setting word |

## Verification
A wrong step counter or a misrouted divider operand appears only when `done` rises, and then as a wrong field of `pll_word` or a wrong `set_word`. The check on each field points to the stage at fault: the VCO rate, the gain search, the display division or the loop reciprocal. A control-state slip shows at once as `done` arriving at the wrong edge or as `in_ready` having the wrong level. A cycle-exact model of the handshake catches this on the first cycle in which the two disagree.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int PLL_W      = 11;
  localparam int SET_W      = 32;
  localparam int DISP_W     = 8;
  localparam int REF_RATIO  = 25000000;
  localparam int LOOP_DIV   = 266000;
  localparam int LOOP_MUL   = 1200000;
  localparam int LOOP_SHIFT = 26;
  localparam int LVDS_MUL   = 70;
  localparam int DSI_MUL    = 10;
  localparam int GAIN_DIV   = 10;
  localparam int DIVOUT_CAP = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } ctl_state_e;

  // order of the six serial divisions; each depends on the earlier ones
  typedef enum logic [2:0] {
    STEP_VCOR  = 3'd0,
    STEP_RATIO = 3'd1,
    STEP_VCOC  = 3'd2,
    STEP_DISP  = 3'd3,
    STEP_LOOP  = 3'd4,
    STEP_SET   = 3'd5
  } calc_step_e;
endpackage

// File: rtl/dpll_flog2.sv
module dpll_flog2 #(
  parameter int W = 32
) (
  input  logic [W-1:0]         x,
  output logic [$clog2(W)-1:0] msb_idx
);
  localparam int L = $clog2(W);

  logic [L-1:0] part [0:L];

  assign part[0] = '0;

  // halving search: try the larger shift first, keep it when bits remain above
  for (genvar k = 0; k < L; k++) begin : g_stage
    localparam int STEP = 1 << (L - 1 - k);
    logic [L:0] probe;
    assign probe = {1'b0, part[k]} + (L+1)'(STEP);
    assign part[k+1] = ((x >> probe) != '0) ? probe[L-1:0] : part[k];
  end

  assign msb_idx = part[L];
endmodule

// File: rtl/dpll_divider.sv
module dpll_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_sh;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den;
  logic [CNT_W-1:0] left;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem, q_sh[NUM_W-1]};
    diff  = trial - {1'b0, den};
    fits  = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_sh <= '0;
      rem  <= '0;
      den  <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_sh <= dividend;
        rem  <= '0;
        den  <= divisor;
        left <= CNT_W'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        q_sh <= {q_sh[NUM_W-2:0], fits};
        rem  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        left <= left - 1'b1;
        if (left == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = q_sh;
endmodule

// File: rtl/dpll_operands.sv
module dpll_operands
  import dpll_pkg::*;
#(
  parameter int CLK_W = 20,
  parameter int BPP_W = 6,
  parameter int CNT_W = 3,
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  calc_step_e               step,
  input  logic                     dsi,
  input  logic [CLK_W-1:0]         clk_khz,
  input  logic [BPP_W-1:0]         bpp,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [DEN_W-1:0]         vcor,
  input  logic [DEN_W-1:0]         vcoc,
  input  logic [DEN_W-1:0]         loop_gain,
  input  logic [$clog2(DEN_W)-1:0] lg2,
  output logic [NUM_W-1:0]         dividend,
  output logic [DEN_W-1:0]         divisor
);
  logic [NUM_W-1:0] rate_num;

  always_comb begin
    if (dsi)
      rate_num = NUM_W'(clk_khz) * NUM_W'(bpp) * NUM_W'(DSI_MUL);
    else
      rate_num = NUM_W'(clk_khz) * NUM_W'(LVDS_MUL);
  end

  always_comb begin
    dividend = '0;
    divisor  = DEN_W'(1);
    case (step)
      STEP_VCOR: begin
        dividend = rate_num;
        divisor  = DEN_W'(cnt);
      end
      STEP_RATIO: begin
        dividend = NUM_W'(REF_RATIO);
        divisor  = vcor;
      end
      STEP_VCOC: begin
        dividend = NUM_W'(vcor) << lg2;
        divisor  = DEN_W'(GAIN_DIV);
      end
      STEP_DISP: begin
        dividend = NUM_W'(vcoc);
        divisor  = DEN_W'(clk_khz);
      end
      STEP_LOOP: begin
        dividend = NUM_W'(vcoc);
        divisor  = DEN_W'(LOOP_DIV);
      end
      STEP_SET: begin
        dividend = (NUM_W'(LOOP_MUL) * NUM_W'(loop_gain)) << LOOP_SHIFT;
        divisor  = vcoc;
      end
      default: begin
        dividend = '0;
        divisor  = DEN_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/dpll_param_calc.sv
module dpll_param_calc
  import dpll_pkg::*;
#(
  parameter int CLK_W = 20,
  parameter int BPP_W = 6,
  parameter int CNT_W = 3,
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             mode_dsi,
  input  logic [CLK_W-1:0] clk_khz,
  input  logic [BPP_W-1:0] bpp,
  input  logic [CNT_W-1:0] lane_cnt,
  output logic             done,
  output logic             error,
  output logic [PLL_W-1:0] pll_word,
  output logic [SET_W-1:0] set_word
);
  localparam int FL_W = $clog2(DEN_W);

  ctl_state_e       st;
  calc_step_e       step;
  logic             r_dsi;
  logic [CLK_W-1:0] r_clk;
  logic [BPP_W-1:0] r_bpp;
  logic [CNT_W-1:0] r_cnt;
  logic [DEN_W-1:0] vcor, ratio, vcoc, loop_gain;
  logic [DISP_W-1:0] disp;

  logic             div_start, div_busy, div_done;
  logic [NUM_W-1:0] div_num, div_q;
  logic [DEN_W-1:0] div_den;
  logic [DEN_W-1:0] q_sat, q_round, ratio_nz;
  logic [FL_W-1:0]  lg2, div_hi;
  logic [1:0]       divout;
  logic             bad_req;

  assign in_ready  = (st == ST_IDLE);
  assign div_start = (st == ST_LAUNCH);
  assign bad_req   = (clk_khz == '0) || (lane_cnt == '0) || (mode_dsi && (bpp == '0));

  // intermediate quotients clamp instead of wrapping
  assign q_sat    = (|div_q[NUM_W-1:DEN_W]) ? '1 : div_q[DEN_W-1:0];
  assign q_round  = (q_sat + DEN_W'(7)) & ~DEN_W'(7);
  assign ratio_nz = (ratio == '0) ? DEN_W'(1) : ratio;

  always_comb begin
    divout = (lg2 > FL_W'(DIVOUT_CAP)) ? 2'(DIVOUT_CAP) : lg2[1:0];
    div_hi = lg2 - FL_W'(divout);
  end

  dpll_flog2 #(.W(DEN_W)) u_flog2 (
    .x       (ratio_nz),
    .msb_idx (lg2)
  );

  dpll_operands #(
    .CLK_W(CLK_W), .BPP_W(BPP_W), .CNT_W(CNT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_ops (
    .step      (step),
    .dsi       (r_dsi),
    .clk_khz   (r_clk),
    .bpp       (r_bpp),
    .cnt       (r_cnt),
    .vcor      (vcor),
    .vcoc      (vcoc),
    .loop_gain (loop_gain),
    .lg2       (lg2),
    .dividend  (div_num),
    .divisor   (div_den)
  );

  dpll_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_num),
    .divisor  (div_den),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      step      <= STEP_VCOR;
      r_dsi     <= 1'b0;
      r_clk     <= '0;
      r_bpp     <= '0;
      r_cnt     <= '0;
      vcor      <= '0;
      ratio     <= '0;
      vcoc      <= '0;
      loop_gain <= '0;
      disp      <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      pll_word  <= '0;
      set_word  <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (in_valid) begin
            if (bad_req) begin
              error <= 1'b1;
            end else begin
              r_dsi <= mode_dsi;
              r_clk <= clk_khz;
              r_bpp <= bpp;
              r_cnt <= lane_cnt;
              step  <= STEP_VCOR;
              st    <= ST_LAUNCH;
            end
          end
        end
        ST_LAUNCH: st <= ST_WAIT;
        ST_WAIT: begin
          if (div_done && !div_busy) begin
            case (step)
              STEP_VCOR:  vcor      <= q_sat;
              STEP_RATIO: ratio     <= q_sat;
              STEP_VCOC:  vcoc      <= q_sat;
              STEP_DISP:  disp      <= div_q[DISP_W-1:0];
              STEP_LOOP:  loop_gain <= q_round;
              default: begin
                set_word <= div_q[SET_W-1:0];
                pll_word <= {div_hi[0], divout, disp};
              end
            endcase
            if (step == STEP_SET) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              step <= calc_step_e'(step + 3'd1);
              st   <= ST_LAUNCH;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpll_param_calc_chk.sv
module dpll_param_calc_chk #(
  parameter int CLK_W = 20,
  parameter int BPP_W = 6,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             mode_dsi,
  input logic [CLK_W-1:0] clk_khz,
  input logic [BPP_W-1:0] bpp,
  input logic [CNT_W-1:0] lane_cnt,
  input logic             done,
  input logic             error,
  input logic [10:0]      pll_word,
  input logic [31:0]      set_word
);
  logic good_take;
  assign good_take = in_valid && in_ready && (clk_khz != '0) && (lane_cnt != '0)
                     && (!mode_dsi || (bpp != '0));

  assert_busy_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    good_take |=> !in_ready);

  assert_field_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_word[9:8] != 2'd3) |-> !pll_word[10]);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!in_ready));

  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!done && in_ready));

  assert_hold_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pll_word));

  assert_hold_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(set_word));
endmodule

bind dpll_param_calc dpll_param_calc_chk #(
  .CLK_W(CLK_W), .BPP_W(BPP_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mode_dsi (mode_dsi),
  .clk_khz  (clk_khz),
  .bpp      (bpp),
  .lane_cnt (lane_cnt),
  .done     (done),
  .error    (error),
  .pll_word (pll_word),
  .set_word (set_word)
);

// File: tb/dpll_param_calc_tb.sv
module dpll_param_calc_tb;
  localparam int LAT = 6 * (64 + 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode_dsi = 1'b0;
  logic [19:0] clk_khz = '0;
  logic [5:0]  bpp = '0;
  logic [2:0]  lane_cnt = '0;
  logic        in_ready, done, error;
  logic [10:0] pll_word;
  logic [31:0] set_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dpll_param_calc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode_dsi(mode_dsi), .clk_khz(clk_khz), .bpp(bpp), .lane_cnt(lane_cnt),
    .done(done), .error(error), .pll_word(pll_word), .set_word(set_word)
  );

  function automatic void expect_words(input bit dsi, input longint unsigned ck,
      input longint unsigned bp, input longint unsigned cn,
      output logic [10:0] pw, output logic [31:0] sw);
    longint unsigned v, r, c, disp, g, s, dout, dhi;
    int d;
    v = dsi ? (ck * bp * 10) / cn : (ck * 70) / cn;
    r = 25000000 / v;
    if (r < 1) r = 1;
    d = 0;
    while ((r >> (d + 1)) != 0) d++;
    c = (v << d) / 10;
    disp = (c / ck) % 256;
    g = ((c / 266000) + 7) / 8 * 8;
    s = ((1200000 * g) << 26) / c;
    dout = (d > 3) ? 3 : d;
    dhi = d - dout;
    pw = 11'(((dhi % 2) << 10) | (dout << 8) | disp);
    sw = 32'(s);
  endfunction

  // behavioural reference of the handshake
  bit          m_busy, m_done, m_err;
  int          m_left;
  logic [10:0] m_pll, m_pend_pll;
  logic [31:0] m_set, m_pend_set;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_err <= 0; m_left <= 0;
      m_pll <= '0; m_set <= '0;
    end else begin
      m_done <= 0;
      m_err  <= 0;
      if (m_busy) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          m_busy <= 0;
          m_done <= 1;
          m_pll  <= m_pend_pll;
          m_set  <= m_pend_set;
        end
      end else if (in_valid) begin
        if (clk_khz == 0 || lane_cnt == 0 || (mode_dsi && bpp == 0)) begin
          m_err <= 1;
        end else begin
          logic [10:0] pw;
          logic [31:0] sw;
          expect_words(mode_dsi, clk_khz, bpp, lane_cnt, pw, sw);
          m_pend_pll <= pw;
          m_pend_set <= sw;
          m_busy <= 1;
          m_left <= LAT;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == !m_busy, "R1 R7 in_ready", in_ready, !m_busy);
      chk(done == m_done, "R7 done pulse", done, m_done);
      chk(error == m_err, "R8 error pulse", error, m_err);
      chk(pll_word[7:0] == m_pll[7:0], "R2 R4 disp field", pll_word[7:0], m_pll[7:0]);
      chk(pll_word[9:8] == m_pll[9:8], "R3 R5 divout field", pll_word[9:8], m_pll[9:8]);
      chk(pll_word[10] == m_pll[10], "R5 div_sel bit", pll_word[10], m_pll[10]);
      chk(set_word == m_set, "R6 R9 set_word", set_word, m_set);
    end
  end

  task automatic issue(input bit dsi, input int ck, input int bp, input int cn);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    mode_dsi = dsi; clk_khz = 20'(ck); bpp = 6'(bp); lane_cnt = 3'(cn);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
    chk(done == 1'b0 && error == 1'b0, "R10 reset pulses", {done, error}, 0);
    chk(pll_word == '0 && set_word == '0, "R10 reset words", {pll_word, set_word}, 0);
    rst_n = 1'b1;

    issue(0, 74250, 0, 1);  wait_idle();   // LVDS single link
    issue(0, 148500, 0, 2); wait_idle();   // LVDS dual link
    issue(1, 148500, 24, 4); wait_idle();  // DSI 24bpp 4 lanes
    issue(1, 27000, 18, 2); wait_idle();   // DSI 18bpp
    issue(1, 1, 1, 7); wait_idle();        // R3 largest gain
    issue(1, 1000000, 63, 1); wait_idle(); // R3 ratio below one, gain 1
    issue(0, 25000, 0, 7); wait_idle();

    // R8 rejected requests
    issue(0, 0, 0, 1);   wait_idle();
    issue(1, 50000, 24, 0); wait_idle();
    issue(1, 50000, 0, 4);  wait_idle();

    // R1 requests while busy are ignored
    issue(1, 65000, 16, 3);
    repeat (20) @(negedge clk);
    mode_dsi = 0; clk_khz = 20'd9999; lane_cnt = 3'd5; in_valid = 1'b1;
    repeat (30) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // back-to-back: second request held and taken in the done cycle
    @(negedge clk);
    mode_dsi = 1; clk_khz = 20'd33000; bpp = 6'd24; lane_cnt = 3'd1; in_valid = 1'b1;
    @(negedge clk);
    clk_khz = 20'd120000; lane_cnt = 3'd4;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule